// File: doc/BRIEF.md
# Data-Memory Address Generator with Step and Circular Modes

This block produces one data-memory address per clock cycle from a small bank of address registers. The instruction picks one register and one operation. The operation either uses that register as it stands, or steps it by one. A step can be an increment taken after use, a decrement taken before use, or an increment that wraps inside a circular buffer. The address output is combinational from the current register contents and the current operation, so memory sees the address in the same cycle that the operation is issued.

A single 16-bit load input from the register file writes an address register or one of the two circular-buffer bounds. The bounds are a first address and a last address, and all address registers share them. When a register in circular mode reaches the last address, its next value is the first address. Every stepping operation uses one shared add-by-plus-or-minus-one unit.

Top module: `dm_addr_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every address register and both buffer bounds to 0x0000.
- R2: Operation code 0 (hold) drives addr_o with the selected register and leaves every register unchanged.
- R3: Operation code 1 (post-increment) drives addr_o with the selected register's current value, and the register becomes that value plus one, modulo 2^16 (0xFFFF steps to 0x0000).
- R4: Operation code 2 (pre-decrement) drives addr_o with the selected register minus one, modulo 2^16, and the register takes that same value (0x0000 steps to 0xFFFF).
- R5: Operation code 3 (circular) drives addr_o with the selected register's current value. The register becomes the first-address bound if its value equals the last-address bound, and its value plus one otherwise. When the two bounds are equal, a register that holds that value keeps it.
- R6: Operation code 4 writes data_i into the selected address register at the clock edge, while addr_o shows the register's old value during that cycle.
- R7: Operation code 5 writes data_i into the first-address bound and code 6 writes it into the last-address bound. Both ignore sel_i, leave the address registers unchanged and drive addr_o with the selected register.
- R8: An operation changes only the register named by sel_i (0 or 1). The other address register keeps its value.
- R9: Operation code 7 is reserved and behaves exactly like hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Address register select |
| op_i | input | 3 | Operation code (0 hold, 1 post-inc, 2 pre-dec, 3 circular, 4 load address, 5 load first bound, 6 load last bound, 7 reserved) |
| data_i | input | 16 | Load value from the register file |
| addr_o | output | 16 | Data-memory address for this cycle |

## Verification
The address output is read straight from the selected register, so a wrong register value appears at addr_o the next time that register is used with hold, post-increment or circular mode. That is usually the cycle right after the faulty update. A wrong bound appears only when a circular walk reaches the last address. For this reason the bench walks a buffer through its wrap point and also covers the degenerate case where the first and last bounds are equal. Cross-register corruption is caught by reading the register that was not selected right after a sequence of updates to the other one.

// File: rtl/dm_addr_pkg.sv
// Package: shared types and constants for the data-memory address generator.
// Assumes: 3-bit operation codes decoded by the top module.
package dm_addr_pkg;

    typedef enum logic [2:0] {
        OP_HOLD    = 3'd0,
        OP_POSTINC = 3'd1,
        OP_PREDEC  = 3'd2,
        OP_CIRC    = 3'd3,
        OP_LDADDR  = 3'd4,
        OP_LDFIRST = 3'd5,
        OP_LDLAST  = 3'd6,
        OP_RSVD    = 3'd7
    } agen_op_e;

    // Control word for the shared stepping unit
    typedef struct packed {
        logic dec;   // step by minus one instead of plus one
        logic pre;   // output the stepped value instead of the current one
        logic wrap;  // replace the step with the first bound at the last bound
    } step_ctl_t;

endpackage

// File: rtl/dm_addr_regbank.sv
// Module: bank of NREG address registers with one write port.
// Assumes: sel_i is already range-checked by the caller via we_i.
module dm_addr_regbank #(
    parameter int AW   = 16,
    parameter int NREG = 2,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [SELW-1:0]           sel_i,
    input  logic [AW-1:0]             wdata_i,
    output logic [NREG-1:0][AW-1:0]   regs_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Purpose: hold one address register, written when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[i] <= '0;
            else if (we_i && (sel_i == SELW'(i)))
                regs_o[i] <= wdata_i;
        end

        // R8: an unselected or unwritten register keeps its value
        a_r8_unselected_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (sel_i == SELW'(i))) |=> $stable(regs_o[i]));
    end

endmodule

// File: rtl/dm_addr_bounds.sv
// Module: first/last bound registers for circular addressing.
// Assumes: at most one of the two load strobes is active per cycle.
module dm_addr_bounds #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_first_i,
    input  logic          ld_last_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] last_o
);

    // Purpose: capture the buffer's first address
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_o <= '0;
        else if (ld_first_i)
            first_o <= data_i;
    end

    // Purpose: capture the buffer's last address
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_o <= '0;
        else if (ld_last_i)
            last_o <= data_i;
    end

    // R7: bounds change only on their own load strobe
    a_r7_first_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_first_i |=> $stable(first_o));
    a_r7_last_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_last_i |=> $stable(last_o));

endmodule

// File: rtl/dm_addr_step.sv
// Module: shared plus/minus-one unit with circular wrap selection.
// Assumes: one adder serves all registers; purely combinational.
module dm_addr_step
    import dm_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  step_ctl_t     ctl_i,
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] next_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] step;
    logic [AW-1:0] sum;
    logic          at_last;

    // Purpose: single adder computing current value plus or minus one
    always_comb begin
        step    = ctl_i.dec ? '1 : ONE;
        sum     = cur_i + step;
        at_last = (cur_i == last_i);
    end

    // Purpose: pick the address seen by memory and the register's next value
    always_comb begin
        addr_o = ctl_i.pre ? sum : cur_i;
        next_o = (ctl_i.wrap && at_last) ? first_i : sum;
    end

endmodule

// File: rtl/dm_addr_gen.sv
// Module: top of the data-memory address generator. Decodes the operation,
// selects one address register, steps it via the shared unit and writes back.
// Assumes: address output is combinational; registers update at the edge.
module dm_addr_gen
    import dm_addr_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 2,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel_i,
    input  logic [2:0]      op_i,
    input  logic [AW-1:0]   data_i,
    output logic [AW-1:0]   addr_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    agen_op_e               op;
    step_ctl_t              ctl;
    logic                   sel_ok;
    logic                   we;
    logic                   ld_first;
    logic                   ld_last;
    logic [NREG-1:0][AW-1:0] regs;
    logic [AW-1:0]          cur;
    logic [AW-1:0]          first_q;
    logic [AW-1:0]          last_q;
    logic [AW-1:0]          step_next;
    logic [AW-1:0]          wdata;

    // Purpose: decode the operation into write, load and step controls
    always_comb begin
        op       = agen_op_e'(op_i);
        sel_ok   = (32'(sel_i) < NREG);
        ctl      = '0;
        we       = 1'b0;
        ld_first = 1'b0;
        ld_last  = 1'b0;
        unique case (op)
            OP_POSTINC: we = sel_ok;
            OP_PREDEC: begin
                ctl.dec = 1'b1;
                ctl.pre = 1'b1;
                we      = sel_ok;
            end
            OP_CIRC: begin
                ctl.wrap = 1'b1;
                we       = sel_ok;
            end
            OP_LDADDR:  we       = sel_ok;
            OP_LDFIRST: ld_first = 1'b1;
            OP_LDLAST:  ld_last  = 1'b1;
            default: ;  // hold and reserved: no update
        endcase
    end

    // Purpose: read the selected register (register 0 if out of range)
    always_comb begin
        cur   = sel_ok ? regs[sel_i] : regs[0];
        wdata = (op == OP_LDADDR) ? data_i : step_next;
    end

    dm_addr_regbank #(.AW(AW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .sel_i   (sel_i),
        .wdata_i (wdata),
        .regs_o  (regs)
    );

    dm_addr_bounds #(.AW(AW)) u_bounds (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_first_i (ld_first),
        .ld_last_i  (ld_last),
        .data_i     (data_i),
        .first_o    (first_q),
        .last_o     (last_q)
    );

    dm_addr_step #(.AW(AW)) u_step (
        .ctl_i   (ctl),
        .cur_i   (cur),
        .first_i (first_q),
        .last_i  (last_q),
        .addr_o  (addr_o),
        .next_o  (step_next)
    );

    // R1: first cycle out of reset sees cleared registers and bounds
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (regs == '0) && (first_q == '0) && (last_q == '0));

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        // R2/R9: hold and reserved keep the register
        a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == 3'd0 || op_i == 3'd7) && sel_i == SELW'(i)) |=> $stable(regs[i]));
        // R3: post-increment outputs current value then adds one
        a_r3_postinc: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd1 && sel_i == SELW'(i)) |=> regs[i] == $past(addr_o) + ONE);
        // R4: pre-decrement output equals the value written back
        a_r4_predec: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd2 && sel_i == SELW'(i)) |=> regs[i] == $past(addr_o));
        // R5: circular step wraps to the first bound at the last bound
        a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd3 && sel_i == SELW'(i) && regs[i] == last_q) |=> regs[i] == $past(first_q));
        // R6: load writes the input into the selected register
        a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd4 && sel_i == SELW'(i)) |=> regs[i] == $past(data_i));
    end

    // R4: pre-decrement address sits one below the selected register
    a_r4_predec_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && sel_ok) |-> addr_o == cur - ONE);

endmodule

// File: tb/dm_addr_gen_tb.sv
module dm_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  sel_i = '0;
    logic [2:0]  op_i = '0;
    logic [15:0] data_i = '0;
    logic [15:0] addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dm_addr_gen u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_i),
        .op_i   (op_i),
        .data_i (data_i),
        .addr_o (addr_o)
    );

    // Vector: {req[3:0], sel, op[2:0], data[15:0], expected addr[15:0]}
    localparam int NV = 22;
    localparam logic [39:0] VEC [NV] = '{
        {4'd1, 1'b0, 3'd0, 16'h0000, 16'h0000},  // R1 reg0 cleared
        {4'd1, 1'b1, 3'd0, 16'h0000, 16'h0000},  // R1 reg1 cleared
        {4'd6, 1'b0, 3'd4, 16'h0010, 16'h0000},  // R6 load reg0, old value out
        {4'd6, 1'b1, 3'd4, 16'h0200, 16'h0000},  // R6 load reg1
        {4'd3, 1'b0, 3'd1, 16'h0000, 16'h0010},  // R3 post-inc
        {4'd3, 1'b0, 3'd1, 16'h0000, 16'h0011},  // R3 post-inc again
        {4'd4, 1'b1, 3'd2, 16'h0000, 16'h01FF},  // R4 pre-dec
        {4'd8, 1'b0, 3'd0, 16'h0000, 16'h0012},  // R8 reg0 untouched by reg1 step
        {4'd2, 1'b1, 3'd0, 16'h0000, 16'h01FF},  // R2 hold shows updated reg1
        {4'd7, 1'b0, 3'd5, 16'h0100, 16'h0012},  // R7 load first bound
        {4'd7, 1'b0, 3'd6, 16'h0102, 16'h0012},  // R7 load last bound
        {4'd7, 1'b0, 3'd0, 16'h0000, 16'h0012},  // R7 reg0 unchanged by bound loads
        {4'd6, 1'b1, 3'd4, 16'h0101, 16'h01FF},  // R6 reload reg1
        {4'd5, 1'b1, 3'd3, 16'h0000, 16'h0101},  // R5 circular step
        {4'd5, 1'b1, 3'd3, 16'h0000, 16'h0102},  // R5 at last bound
        {4'd5, 1'b1, 3'd3, 16'h0000, 16'h0100},  // R5 wrapped to first
        {4'd9, 1'b0, 3'd7, 16'hABCD, 16'h0012},  // R9 reserved acts as hold
        {4'd9, 1'b0, 3'd0, 16'h0000, 16'h0012},  // R9 reg0 still unchanged
        {4'd6, 1'b0, 3'd4, 16'hFFFF, 16'h0012},  // R6 load top of range
        {4'd3, 1'b0, 3'd1, 16'h0000, 16'hFFFF},  // R3 FFFF then wraps to 0
        {4'd4, 1'b0, 3'd2, 16'h0000, 16'hFFFF},  // R4 0 minus one is FFFF
        {4'd8, 1'b1, 3'd0, 16'h0000, 16'h0101}   // R8 reg1 kept through reg0 ops
    };

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (addr_o !== exp) begin
            failures++;
            $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // Drive at falling edge, sample before the next rising edge
    task automatic step(input logic s, input logic [2:0] op, input logic [15:0] d,
                        input string req, input logic [15:0] exp);
        @(negedge clk);
        sel_i = s; op_i = op; data_i = d;
        #2;
        check(req, exp);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][35], VEC[i][34:32], VEC[i][31:16],
                 $sformatf("R%0d vec%0d", VEC[i][39:36], i), VEC[i][15:0]);
        end

        // R5 corner: equal bounds hold a register on its single address
        step(1'b0, 3'd5, 16'h0050, "R7 set first=0050", 16'hFFFF);
        step(1'b0, 3'd6, 16'h0050, "R7 set last=0050", 16'hFFFF);
        step(1'b0, 3'd4, 16'h0050, "R6 load 0050", 16'hFFFF);
        step(1'b0, 3'd3, 16'h0000, "R5 equal bounds first", 16'h0050);
        step(1'b0, 3'd3, 16'h0000, "R5 equal bounds stays", 16'h0050);
        step(1'b0, 3'd0, 16'h0000, "R5 equal bounds hold", 16'h0050);

        // R1: mid-run reset clears registers and bounds
        @(negedge clk); rst_n = 1'b0; op_i = 3'd0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 3'd0, 16'h0000, "R1 reg0 after reset", 16'h0000);
        step(1'b1, 3'd0, 16'h0000, "R1 reg1 after reset", 16'h0000);
        // Bounds are 0/0: circular step on 0 stays at 0
        step(1'b1, 3'd3, 16'h0000, "R1 circular at cleared bounds", 16'h0000);
        step(1'b1, 3'd0, 16'h0000, "R1 bounds cleared, reg1 wraps to 0", 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule